// File: doc/BRIEF.md
# Direct-Sequence Spreading Modulator

This block spreads a serial data stream with a pseudo-noise chip code. A host loads a 16-bit hold register one byte at a time. A start pulse copies that register into a shift register, points the code counter at a programmable start address and begins transmission. On every active chip strobe the block reads one chip from a fixed on-chip code ROM. The spread output carries that chip XORed with the current data bit. In raw mode it carries the bare chip.

The data bit advances at a programmable ratio to the code sequence. When the last bit of a word leaves, the shift register refills from the hold register on the same strobe. An interrupt pulse is raised and a sticky flag is set, so the host can refill the hold register while the next word is being sent. A global enable freezes all state. Separate output enables gate the chip clock, data bit and data clock outputs.

Top module: `dsss_spreader`

## Requirements
- R1: After reset the block is idle. irq, irq_flag, spread_out, data_out, chip_clk_out and data_clk_out are all 0, and strobes have no effect until a start.
- R2: A cycle with en=1 and start=1 resets the chip index to 0, the bit position to 0 and the chip-in-word count to 0. It copies the hold register into the shift register, and transmission runs from then on. The start overrides a strobe in the same cycle.
- R3: Chip i of a sequence is read at address (seq_start + i) mod 64. The index wraps to 0 after seq_len chips. The ROM bit at address a is the XOR of the bits of (a AND 6'h2D).
- R4: With raw_sel=0, spread_out = chip XOR current data bit. Data bits leave least significant bit first.
- R5: With raw_sel=1, spread_out equals the chip alone, whatever the data.
- R6: The data bit advances every P active strobes. ratio_mode sets P: 0 gives P=seq_len; 1 gives seq_len/2; 2 gives seq_len/4; 3 gives 2*seq_len; 4 gives 4*seq_len; 5 gives dclk_div+1.
- R7: On the strobe that moves past bit 15 the shift register reloads from the hold register. Hold writes made during a word do not change the word being sent.
- R8: irq is a one-cycle pulse in the cycle after the reloading strobe edge. irq_flag is set at the same edge and cleared by a wr_hi write. Setting wins over clearing.
- R9: wr_lo writes wr_data into hold bits 7:0 and wr_hi writes it into bits 15:8. Each write leaves the other half unchanged.
- R10: While en=0, strobes and start are ignored, the state is frozen, and spread_out and data_out hold their values.
- R11: chip_clk_out = chclk_oe AND an active strobe. data_clk_out = dclk_oe AND a strobe on which the data bit advances. data_out = dout_oe AND the current data bit. spread_out needs no output enable.
- R12: Without chip_stb, apart from start, the chip index and data state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable |
| chip_stb | input | 1 | Chip-rate strobe |
| start | input | 1 | Start or restart transmission |
| wr_lo | input | 1 | Write low byte of hold register |
| wr_hi | input | 1 | Write high byte of hold register, clear irq_flag |
| wr_data | input | 8 | Host write data |
| seq_start | input | 6 | Code start address |
| seq_len | input | 7 | Sequence length in chips |
| ratio_mode | input | 3 | Chips-to-bit ratio select |
| dclk_div | input | 8 | Data period minus one in mode 5 |
| raw_sel | input | 1 | 1: bare chip output |
| chclk_oe | input | 1 | Chip clock output enable |
| dout_oe | input | 1 | Data bit output enable |
| dclk_oe | input | 1 | Data clock output enable |
| spread_out | output | 1 | Spread chip stream |
| chip_clk_out | output | 1 | Chip clock pulse |
| data_out | output | 1 | Current data bit |
| data_clk_out | output | 1 | Data clock pulse |
| irq | output | 1 | Reload interrupt pulse |
| irq_flag | output | 1 | Latched reload interrupt |

## Verification
The first corner case is the code address running past the top of the ROM. A design that failed to wrap modulo 64 would read the wrong chips. The bench drives every ratio mode, so a design with a wrong bit period shows data bits and data clock pulses in the wrong cycles. A design that used the hold register as the live data would change a word while it is being sent; the bench writes the hold register mid-word, once in both halves and once in the high half only, to expose this. A design that moved on disabled or missing strobes, or ignored a mid-run restart, would lose chip alignment and fail the per-chip comparison. The irq pulse and the flag clear are checked at their exact cycles.

// File: rtl/dsss_spreader.sv
`timescale 1ns/1ps
module dsss_spreader #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int DIVW = 8,
  parameter logic [AW-1:0] ROM_MASK = 6'h2D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            chip_stb,
  input  logic            start,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [DW/2-1:0] wr_data,
  input  logic [AW-1:0]   seq_start,
  input  logic [AW:0]     seq_len,
  input  logic [2:0]      ratio_mode,
  input  logic [DIVW-1:0] dclk_div,
  input  logic            raw_sel,
  input  logic            chclk_oe,
  input  logic            dout_oe,
  input  logic            dclk_oe,
  output logic            spread_out,
  output logic            chip_clk_out,
  output logic            data_out,
  output logic            data_clk_out,
  output logic            irq,
  output logic            irq_flag
);
  localparam int HB  = DW / 2;
  localparam int LW  = AW + 1;
  localparam int CW  = (AW + 3 > DIVW + 1) ? AW + 3 : DIVW + 1;
  localparam int BPW = $clog2(DW);

  logic [2**AW-1:0] rom;
  for (genvar a = 0; a < 2**AW; a++) begin : g_rom
    assign rom[a] = ^(ROM_MASK & AW'(a));
  end

  logic           run;
  logic [AW-1:0]  idx;
  logic [CW-1:0]  bcnt;
  logic [DW-1:0]  hold, sh;
  logic [BPW-1:0] bpos;

  logic [LW-1:0] len_m1;
  logic [CW-1:0] per_raw, per;
  logic [AW-1:0] addr;
  logic          chip, act, adv, wrap, last, go;

  assign len_m1 = (seq_len == '0) ? '0 : seq_len - 1'b1;
  assign addr   = seq_start + idx;
  assign chip   = rom[addr];
  assign go     = en & start;
  assign act    = en & run & chip_stb & ~start;
  assign wrap   = ({1'b0, idx} == len_m1);
  assign adv    = act & (bcnt == per - 1'b1);
  assign last   = (bpos == BPW'(DW - 1));

  always_comb begin
    case (ratio_mode)
      3'd1:    per_raw = CW'(seq_len >> 1);
      3'd2:    per_raw = CW'(seq_len >> 2);
      3'd3:    per_raw = CW'(seq_len) << 1;
      3'd4:    per_raw = CW'(seq_len) << 2;
      3'd5:    per_raw = CW'(dclk_div) + 1'b1;
      default: per_raw = CW'(seq_len);
    endcase
    per = (per_raw == '0) ? CW'(1) : per_raw;
  end

  assign spread_out   = run & (chip ^ (~raw_sel & sh[0]));
  assign data_out     = dout_oe & run & sh[0];
  assign chip_clk_out = chclk_oe & act;
  assign data_clk_out = dclk_oe & adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      idx      <= '0;
      bcnt     <= '0;
      hold     <= '0;
      sh       <= '0;
      bpos     <= '0;
      irq      <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (wr_lo) hold[HB-1:0]  <= wr_data;
      if (wr_hi) hold[DW-1:HB] <= wr_data;
      if (wr_hi) irq_flag <= 1'b0;
      if (go) begin
        run  <= 1'b1;
        idx  <= '0;
        bcnt <= '0;
        sh   <= hold;
        bpos <= '0;
      end else if (act) begin
        idx <= wrap ? '0 : idx + 1'b1;
        if (adv) begin
          bcnt <= '0;
          if (last) begin
            sh       <= hold;
            bpos     <= '0;
            irq      <= 1'b1;
            irq_flag <= 1'b1;
          end else begin
            sh   <= sh >> 1;
            bpos <= bpos + 1'b1;
          end
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dsss_spreader_chk.sv
`timescale 1ns/1ps
module dsss_spreader_chk #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int CW = 9,
  parameter int BPW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           start,
  input logic           chip_stb,
  input logic           chclk_oe,
  input logic           irq,
  input logic           irq_flag,
  input logic           chip_clk_out,
  input logic           data_clk_out,
  input logic           run,
  input logic [AW-1:0]  idx,
  input logic [CW-1:0]  bcnt,
  input logic [DW-1:0]  sh,
  input logic [BPW-1:0] bpos
);
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n) en && start |=> run && idx == '0 && bpos == '0 && bcnt == '0); // R2
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R8
  AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq |-> irq_flag); // R8
  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !en |=> $stable(idx) && $stable(sh) && $stable(bcnt) && $stable(bpos)); // R10
  AST_NO_CLK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !en |-> !chip_clk_out && !data_clk_out); // R10
  AST_CHIP_CLK_GATED: assert property (@(posedge clk) disable iff (!rst_n) chip_clk_out |-> chclk_oe && chip_stb && run); // R11
  AST_IDLE_WITHOUT_STB: assert property (@(posedge clk) disable iff (!rst_n) !chip_stb && !start |=> $stable(idx) && $stable(sh)); // R12
endmodule

bind dsss_spreader dsss_spreader_chk #(.AW(AW), .DW(DW), .CW(CW), .BPW(BPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .start(start), .chip_stb(chip_stb),
  .chclk_oe(chclk_oe), .irq(irq), .irq_flag(irq_flag),
  .chip_clk_out(chip_clk_out), .data_clk_out(data_clk_out),
  .run(run), .idx(idx), .bcnt(bcnt), .sh(sh), .bpos(bpos)
);

// File: tb/tb_dsss_spreader.sv
`timescale 1ns/1ps
module tb_dsss_spreader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, chip_stb = 1'b0, start = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0] wr_data = '0;
  logic [5:0] seq_start = '0;
  logic [6:0] seq_len = 7'd16;
  logic [2:0] ratio_mode = '0;
  logic [7:0] dclk_div = '0;
  logic raw_sel = 1'b0, chclk_oe = 1'b1, dout_oe = 1'b1, dclk_oe = 1'b1;
  logic spread_out, chip_clk_out, data_out, data_clk_out, irq, irq_flag;

  always #10 clk = ~clk;

  dsss_spreader dut (.*);

  int nchk = 0, nerr = 0;
  int g_mode, g_len, g_sa, g_raw, g_div, g_p;
  logic [15:0] g_d;

  typedef struct packed {
    logic [2:0] mode; logic [6:0] len; logic [5:0] sa; logic raw;
    logic [7:0] div; logic [15:0] data; logic [11:0] n;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{3'd0, 7'd16, 6'd0,  1'b0, 8'd0, 16'hA5C3, 12'd300},
    '{3'd1, 7'd32, 6'd10, 1'b0, 8'd0, 16'h3C96, 12'd300},
    '{3'd2, 7'd16, 6'd56, 1'b0, 8'd0, 16'hF00D, 12'd150},
    '{3'd3, 7'd8,  6'd3,  1'b0, 8'd0, 16'h5A0F, 12'd300},
    '{3'd4, 7'd4,  6'd60, 1'b0, 8'd0, 16'h8421, 12'd300},
    '{3'd5, 7'd7,  6'd20, 1'b0, 8'd2, 16'hC3E1, 12'd120},
    '{3'd0, 7'd12, 6'd33, 1'b1, 8'd0, 16'hFFFF, 12'd60},
    '{3'd0, 7'd1,  6'd9,  1'b0, 8'd0, 16'h6B2D, 12'd40}
  };

  function automatic logic chip_f(int a);
    logic [5:0] x;
    x = 6'(a);
    return ^(x & 6'h2D);
  endfunction

  function automatic int period_f(int m, int l, int d);
    int p;
    case (m)
      1: p = l / 2;
      2: p = l / 4;
      3: p = l * 2;
      4: p = l * 4;
      5: p = d + 1;
      default: p = l;
    endcase
    return (p == 0) ? 1 : p;
  endfunction

  task automatic chk(input string rq, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic wr_hold(input logic [7:0] lo, input logic [7:0] hi, input logic do_lo, input logic do_hi);
    if (do_lo) begin wr_data = lo; wr_lo = 1'b1; @(negedge clk); wr_lo = 1'b0; end
    if (do_hi) begin wr_data = hi; wr_hi = 1'b1; @(negedge clk); wr_hi = 1'b0; end
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic configure(input int m, input int l, input int sa, input int raw, input int d, input logic [15:0] data);
    g_mode = m; g_len = l; g_sa = sa; g_raw = raw; g_div = d; g_d = data;
    g_p = period_f(m, l, d);
    ratio_mode = 3'(m); seq_len = 7'(l); seq_start = 6'(sa); raw_sel = raw[0]; dclk_div = 8'(d);
    wr_hold(data[7:0], data[15:8], 1'b1, 1'b1);
    pulse_start();
  endtask

  // one active chip: check state k, strobe it, check the pulses and the irq that follows
  task automatic model_cycle(input int k, input string rq);
    int b; logic c, eb, edc;
    c = chip_f(g_sa + (k % g_len));
    eb = g_d[(k / g_p) % 16];
    edc = ((k + 1) % g_p) == 0;
    chk(rq, "spread_out", spread_out, g_raw ? c : c ^ eb);
    chk(rq, "data_out", data_out, dout_oe & eb);
    chip_stb = 1'b1;
    #1;
    chk("R11", "chip_clk_out", chip_clk_out, chclk_oe);
    chk("R6", "data_clk_out", data_clk_out, dclk_oe & edc);
    @(negedge clk);
    chip_stb = 1'b0;
    b = ((k + 1) % (16 * g_p)) == 0;
    chk("R8", "irq", irq, b);
  endtask

  task automatic word_cycle(input logic eb, input logic eirq, input string rq);
    logic c;
    c = chip_f(g_sa);
    chk(rq, "spread_out", spread_out, c ^ eb);
    chk(rq, "data_out", data_out, eb);
    chip_stb = 1'b1;
    @(negedge clk);
    chip_stb = 1'b0;
    chk("R8", "irq", irq, eirq);
  endtask

  initial begin
    #4000000;
    nchk++; nerr++;
    $display("FAIL R1 watchdog: got %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [15:0] w;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    chip_stb = 1'b1;
    #1;
    chk("R1", "irq", irq, 0);
    chk("R1", "irq_flag", irq_flag, 0);
    chk("R1", "spread_out", spread_out, 0);
    chk("R1", "data_out", data_out, 0);
    chk("R1", "chip_clk_out", chip_clk_out, 0);
    chk("R1", "data_clk_out", data_clk_out, 0);
    @(negedge clk);
    chip_stb = 1'b0;
    chk("R1", "idle after strobe", spread_out, 0);

    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VECS[i];
      configure(int'(v.mode), int'(v.len), int'(v.sa), int'(v.raw), int'(v.div), v.data);
      for (int j = 0; j < int'(v.n); j++)
        model_cycle(j, v.raw ? "R5" : (v.mode == 0 ? "R3 R4" : "R6"));
    end

    // freeze under en=0
    configure(0, 16, 5, 0, 0, 16'h1234);
    for (int j = 0; j < 5; j++) model_cycle(j, "R3");
    en = 1'b0;
    w = {14'd0, spread_out, data_out};
    for (int j = 0; j < 8; j++) begin
      chip_stb = 1'b1; start = (j == 3);
      #1;
      chk("R10", "chip_clk_out off", chip_clk_out, 0);
      @(negedge clk);
      chk("R10", "held outputs", {spread_out, data_out}, w[1:0]);
    end
    chip_stb = 1'b0; start = 1'b0;
    en = 1'b1;
    for (int j = 5; j < 9; j++) model_cycle(j, "R10");

    // no strobe: nothing moves
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      chk("R12", "spread without strobe", spread_out, chip_f(5 + 9) ^ g_d[0]);
    end
    for (int j = 9; j < 20; j++) model_cycle(j, "R12");

    // output enables off
    chclk_oe = 1'b0; dout_oe = 1'b0; dclk_oe = 1'b0;
    for (int j = 20; j < 36; j++) model_cycle(j, "R11");
    chclk_oe = 1'b1; dout_oe = 1'b1; dclk_oe = 1'b1;

    // restart mid-run
    pulse_start();
    for (int j = 0; j < 20; j++) model_cycle(j, "R2");

    // double-buffered reload, per-half writes, flag
    configure(5, 1, 7, 0, 0, 16'h00FF);
    chk("R8", "flag cleared by wr_hi", irq_flag, 0);
    w = 16'h00FF;
    for (int j = 0; j < 16; j++) begin
      if (j == 4) wr_hold(8'hF0, 8'hA5, 1'b1, 1'b1);
      word_cycle(w[j], j == 15, "R7");
    end
    chk("R8", "flag set", irq_flag, 1);
    w = 16'hA5F0;
    for (int j = 0; j < 16; j++) begin
      if (j == 2) begin
        wr_hold(8'h00, 8'h0F, 1'b0, 1'b1);
        chk("R8", "flag cleared", irq_flag, 0);
      end
      word_cycle(w[j], j == 15, "R7 R9");
    end
    w = 16'h0FF0;
    k = 0;
    for (int j = 0; j < 16; j++) begin
      word_cycle(w[j], j == 15, "R9");
      k++;
    end
    chk("R8", "flag set again", irq_flag, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule